// File: doc/BRIEF.md
# Paged External Memory Space Decoder

This block sits between an address generator and the off-chip memory pins. Each request carries an 8-bit page and a 16-bit offset, or for I/O accesses an 8-bit I/O page and a 10-bit immediate. The block decodes the request to one of four external bank selects, the boot-space select, the external I/O select, or one of two internal targets: the on-chip boot ROM and the reserved on-chip peripheral I/O window. For an internal target it only raises a flag.

For an external target it runs a bus cycle. The timing comes from that space's own configuration register: read and write wait counts, strobe polarity, a write hold extension and an 8-bit or 16-bit bus. On an 8-bit bus a 16-bit access is split into two byte transfers, and the result is reported by a single one-cycle `done` pulse.

Bank boundaries are not fixed. Writable boundary registers hold the first page of banks 1 to 3, so the split of the external page range can be moved at run time.

Top module: `xmd_space_decoder`

## Requirements
- R1: For memory and boot requests `ext_addr` equals page·65536 + offset. For I/O requests it equals io_page·1024 + immediate, zero-extended from 18 bits.
- R2: After reset, memory requests to pages 1–63 assert `bank_cs[0]`, pages 64–127 `bank_cs[1]`, pages 128–191 `bank_cs[2]` and pages 192–254 `bank_cs[3]`.
- R3: A memory request to page 0 asserts no select and no strobe. A memory request to page 255 asserts no bank select and raises `rom_sel` together with `done`.
- R4: A boot request (`req_kind`=1) to pages 0–62 asserts `boot_cs`. A boot request to page 63 or above asserts no select.
- R5: An I/O request (`req_kind`=2) whose 18-bit address is below 8192 asserts no select and raises `io_onchip` together with `done`. From 8192 upward it asserts `io_cs`.
- R6: Writing `cfg_addr` 8, 9 or 10 sets the first page of bank 1, 2 or 3 from `cfg_wdata[7:0]`. Bank 0 always starts at page 1. A page maps to the highest bank whose first page is not above it.
- R7: The configuration registers sit at `cfg_addr` 0–3 (banks 0–3), 4 (external I/O) and 5 (boot), and reset to zero. Bits [3:0] hold the read wait count and bits [7:4] the write wait count. Each transfer keeps its strobe active for wait+1 cycles.
- R8: Bit 8 sets strobe polarity: 0 means active-low and 1 means active-high. After reset both strobes are high. When idle, the strobes rest at the inactive level of the last external access.
- R9: When bit 9 is set, each write strobe is followed by one cycle with the select still asserted, the strobe inactive and `ext_oe` high. Reads are unaffected.
- R10: When bit 10 is set, an access is done as two transfers: first with `ext_byte_hi`=0, then with `ext_byte_hi`=1. Write bytes appear on `ext_dout[7:0]`, low byte first. Read bytes are taken from `ext_din[7:0]` and assembled into `rdata` as {second, first}. `done` follows the second transfer only.
- R11: `req` is accepted only while `busy` is low, and a `req` raised while `busy` is high is ignored. `done` is a one-cycle pulse in the cycle after the last strobe or hold cycle, or in the cycle after acceptance when there is no external target. At most one select is active at a time, and a strobe is active only while a select is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration / boundary register write strobe |
| cfg_addr | input | 4 | Register address (0–5 spaces, 8–10 boundaries) |
| cfg_wdata | input | 11 | Register write data |
| req | input | 1 | Access request |
| req_kind | input | 2 | 0 memory, 1 boot, 2 I/O |
| req_write | input | 1 | 1 write, 0 read |
| req_page | input | 8 | Page for memory and boot requests |
| req_offset | input | 16 | Offset within the page |
| io_page | input | 8 | I/O page value |
| io_imm | input | 10 | I/O immediate |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data |
| bank_cs | output | 4 | External bank selects, active high |
| boot_cs | output | 1 | Boot space select, active high |
| io_cs | output | 1 | External I/O select, active high |
| rom_sel | output | 1 | On-chip boot ROM hit, with done |
| io_onchip | output | 1 | Reserved on-chip I/O hit, with done |
| ext_addr | output | 24 | Word address of the access |
| ext_byte_hi | output | 1 | High-byte transfer on an 8-bit bus |
| rd_strb | output | 1 | Read strobe, programmed polarity |
| wr_strb | output | 1 | Write strobe, programmed polarity |
| ext_oe | output | 1 | Write data driven on ext_dout |
| ext_dout | output | 16 | Write data to the bus |
| ext_din | input | 16 | Read data from the bus |

## Verification
The bound checker watches the following on every cycle:
- the selects stay mutually exclusive;
- `rom_sel` and `io_onchip` never coincide with an external select;
- no strobe fires without a select;
- the two strobes never overlap and rest at one common idle level;
- `done` never lasts two cycles;
- a request raised while busy never disturbs the address in flight.

The bench's scenarios cover what depends on programmed state and on counts over a whole access:
- the decoded target for each page and I/O address, including the edges of the reset map and of moved boundaries;
- strobe lengths per wait count;
- hold cycles per write;
- the byte order and the assembled data on the 8-bit bus.

// File: rtl/xmd_pkg.sv
package xmd_pkg;
  localparam int PAGE_W = 8;
  localparam int OFS_W  = 16;
  localparam int ADDR_W = PAGE_W + OFS_W;
  localparam int IMM_W  = 10;
  localparam int IO_W   = PAGE_W + IMM_W;
  localparam int WAIT_W = 4;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    KIND_MEM  = 2'd0,
    KIND_BOOT = 2'd1,
    KIND_IO   = 2'd2,
    KIND_RSVD = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_BANK  = 3'd1,
    TGT_BOOT  = 3'd2,
    TGT_IOEXT = 3'd3,
    TGT_ROM   = 3'd4,
    TGT_IOINT = 3'd5
  } tgt_e;

  // Field order matches the write-data layout: [10] width8, [9] hold,
  // [8] polarity, [7:4] write wait, [3:0] read wait.
  typedef struct packed {
    logic              width8;
    logic              hold;
    logic              pol;
    logic [WAIT_W-1:0] wwait;
    logic [WAIT_W-1:0] rwait;
  } spcfg_t;

  localparam int CFG_W = $bits(spcfg_t);

  function automatic logic [ADDR_W-1:0] word_addr(input logic [PAGE_W-1:0] pg,
                                                  input logic [OFS_W-1:0]  ofs);
    return {pg, ofs};
  endfunction

  function automatic logic [ADDR_W-1:0] io_addr(input logic [PAGE_W-1:0] pg,
                                                input logic [IMM_W-1:0]  imm);
    return {{(ADDR_W-IO_W){1'b0}}, pg, imm};
  endfunction

  function automatic logic [WAIT_W-1:0] wait_of(input spcfg_t c, input logic wr);
    return wr ? c.wwait : c.rwait;
  endfunction

  function automatic logic is_external(input tgt_e t);
    return (t == TGT_BANK) || (t == TGT_BOOT) || (t == TGT_IOEXT);
  endfunction
endpackage

// File: rtl/xmd_bank_map.sv
module xmd_bank_map
  import xmd_pkg::*;
#(
  parameter int NBANK     = 4,
  parameter int BANK_SPAN = 64,
  parameter int ROM_PAGE  = 255,
  localparam int IDX_W    = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_we,
  input  logic [IDX_W-1:0]  bnd_idx,
  input  logic [PAGE_W-1:0] bnd_wdata,
  input  logic [PAGE_W-1:0] page,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [PAGE_W-1:0] bnd [NBANK];

  function automatic logic [PAGE_W-1:0] reset_start(input int k);
    return (k == 0) ? PAGE_W'(1) : PAGE_W'(k * BANK_SPAN);
  endfunction

  // Bank 0 start is never writable; index 0 writes are dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) bnd[i] <= reset_start(i);
    end else if (bnd_we && (bnd_idx != '0)) begin
      bnd[bnd_idx] <= bnd_wdata;
    end
  end

  // Highest bank whose start is not above the page wins.
  always_comb begin
    idx = '0;
    for (int i = 1; i < NBANK; i++) begin
      if (page >= bnd[i]) idx = IDX_W'(i);
    end
  end

  assign hit = (page != '0) && (page != PAGE_W'(ROM_PAGE));
endmodule

// File: rtl/xmd_space_cfg.sv
module xmd_space_cfg
  import xmd_pkg::*;
#(
  parameter int NSPACE = 6,
  parameter int AW     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [CFG_W-1:0]        wdata,
  output spcfg_t [NSPACE-1:0]     cfg_o
);
  for (genvar g = 0; g < NSPACE; g++) begin : g_space
    spcfg_t r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else if (we && (waddr == AW'(g))) r <= spcfg_t'(wdata);
    end
    assign cfg_o[g] = r;
  end
endmodule

// File: rtl/xmd_target_decode.sv
module xmd_target_decode
  import xmd_pkg::*;
#(
  parameter int NBANK      = 4,
  parameter int BOOT_PAGES = 63,
  parameter int IO_RSV     = 8192,
  localparam int IDX_W     = $clog2(NBANK),
  localparam int NSPACE    = NBANK + 2,
  localparam int SPW       = $clog2(NSPACE)
) (
  input  kind_e             kind,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [PAGE_W-1:0] io_pg,
  input  logic [IMM_W-1:0]  io_im,
  input  logic              bank_hit,
  input  logic [IDX_W-1:0]  bank_idx,
  output tgt_e              tgt,
  output logic [ADDR_W-1:0] addr,
  output logic [SPW-1:0]    space
);
  logic [ADDR_W-1:0] ioa;
  assign ioa = io_addr(io_pg, io_im);

  always_comb begin
    tgt   = TGT_NONE;
    addr  = word_addr(page, ofs);
    space = SPW'(bank_idx);
    case (kind)
      KIND_MEM: begin
        if (bank_hit)                              tgt = TGT_BANK;
        else if (page == {PAGE_W{1'b1}})           tgt = TGT_ROM;
      end
      KIND_BOOT: begin
        space = SPW'(NBANK + 1);
        if (page < PAGE_W'(BOOT_PAGES))            tgt = TGT_BOOT;
      end
      KIND_IO: begin
        addr  = ioa;
        space = SPW'(NBANK);
        tgt   = (ioa < ADDR_W'(IO_RSV)) ? TGT_IOINT : TGT_IOEXT;
      end
      default: tgt = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/xmd_access_seq.sv
module xmd_access_seq
  import xmd_pkg::*;
#(
  parameter int NBANK   = 4,
  localparam int IDX_W  = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  tgt_e              tgt,
  input  logic [IDX_W-1:0]  bank_idx,
  input  logic [ADDR_W-1:0] addr,
  input  spcfg_t            cfg,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ext_din,
  output logic              busy,
  output logic              done,
  output logic [NBANK-1:0]  bank_cs,
  output logic              boot_cs,
  output logic              io_cs,
  output logic              rom_sel,
  output logic              io_onchip,
  output logic              rd_strb,
  output logic              wr_strb,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_byte_hi,
  output logic [DATA_W-1:0] ext_dout,
  output logic              ext_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_act,
  output logic              wr_act
);
  typedef enum logic [1:0] {S_IDLE, S_STRB, S_HOLD, S_DONE} st_e;

  st_e               st;
  logic [WAIT_W-1:0] cnt;
  logic              byte_hi;
  logic              is_wr;
  spcfg_t            cfg_q;
  tgt_e              tgt_q;
  logic [IDX_W-1:0]  bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;

  logic sel_on, more_bytes, last_beat;
  assign sel_on     = (st == S_STRB) || (st == S_HOLD);
  assign more_bytes = cfg_q.width8 && !byte_hi;
  assign last_beat  = (st == S_STRB) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      byte_hi <= 1'b0;
      is_wr   <= 1'b0;
      cfg_q   <= '0;
      tgt_q   <= TGT_NONE;
      bank_q  <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          tgt_q   <= tgt;
          bank_q  <= bank_idx;
          addr_q  <= addr;
          is_wr   <= wr;
          wd_q    <= wdata;
          byte_hi <= 1'b0;
          if (is_external(tgt)) begin
            cfg_q <= cfg;
            cnt   <= wait_of(cfg, wr);
            st    <= S_STRB;
          end else begin
            st    <= S_DONE;
          end
        end
        S_STRB: begin
          if (!last_beat) begin
            cnt <= cnt - 1'b1;
          end else begin
            if (!is_wr) begin
              if (!cfg_q.width8)  rd_q              <= ext_din;
              else if (byte_hi)   rd_q[DATA_W-1:BYTE_W] <= ext_din[BYTE_W-1:0];
              else                rd_q[BYTE_W-1:0]  <= ext_din[BYTE_W-1:0];
            end
            if (is_wr && cfg_q.hold) begin
              st <= S_HOLD;
            end else if (more_bytes) begin
              byte_hi <= 1'b1;
              cnt     <= wait_of(cfg_q, is_wr);
            end else begin
              st <= S_DONE;
            end
          end
        end
        S_HOLD: begin
          if (more_bytes) begin
            byte_hi <= 1'b1;
            cnt     <= wait_of(cfg_q, is_wr);
            st      <= S_STRB;
          end else begin
            st <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_cs
    assign bank_cs[g] = sel_on && (tgt_q == TGT_BANK) && (bank_q == IDX_W'(g));
  end

  assign boot_cs     = sel_on && (tgt_q == TGT_BOOT);
  assign io_cs       = sel_on && (tgt_q == TGT_IOEXT);
  assign rom_sel     = (st == S_DONE) && (tgt_q == TGT_ROM);
  assign io_onchip   = (st == S_DONE) && (tgt_q == TGT_IOINT);
  assign rd_act      = (st == S_STRB) && !is_wr;
  assign wr_act      = (st == S_STRB) &&  is_wr;
  assign rd_strb     = cfg_q.pol ? rd_act : !rd_act;
  assign wr_strb     = cfg_q.pol ? wr_act : !wr_act;
  assign ext_addr    = addr_q;
  assign ext_byte_hi = sel_on && cfg_q.width8 && byte_hi;
  assign ext_oe      = sel_on && is_wr;
  assign ext_dout    = cfg_q.width8
                       ? {{(DATA_W-BYTE_W){1'b0}},
                          (byte_hi ? wd_q[DATA_W-1:BYTE_W] : wd_q[BYTE_W-1:0])}
                       : wd_q;
  assign rdata       = rd_q;
  assign busy        = (st != S_IDLE);
  assign done        = (st == S_DONE);
endmodule

// File: rtl/xmd_space_decoder.sv
module xmd_space_decoder
  import xmd_pkg::*;
#(
  parameter int NBANK      = 4,
  parameter int BANK_SPAN  = 64,
  parameter int BOOT_PAGES = 63,
  parameter int IO_RSV     = 8192,
  parameter int CFG_AW     = 4,
  parameter int BND_BASE   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_addr,
  input  logic [10:0]       cfg_wdata,
  input  logic              req,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [7:0]        req_page,
  input  logic [15:0]       req_offset,
  input  logic [7:0]        io_page,
  input  logic [9:0]        io_imm,
  input  logic [15:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rdata,
  output logic [3:0]        bank_cs,
  output logic              boot_cs,
  output logic              io_cs,
  output logic              rom_sel,
  output logic              io_onchip,
  output logic [23:0]       ext_addr,
  output logic              ext_byte_hi,
  output logic              rd_strb,
  output logic              wr_strb,
  output logic              ext_oe,
  output logic [15:0]       ext_dout,
  input  logic [15:0]       ext_din
);
  localparam int IDX_W  = $clog2(NBANK);
  localparam int NSPACE = NBANK + 2;
  localparam int SPW    = $clog2(NSPACE);

  // Register-file decode of the configuration port.
  logic               bnd_we;
  logic [CFG_AW-1:0]  bnd_off;
  logic [IDX_W-1:0]   bnd_idx;
  assign bnd_we  = cfg_wr && (cfg_addr >= CFG_AW'(BND_BASE))
                          && (cfg_addr <  CFG_AW'(BND_BASE + NBANK - 1));
  assign bnd_off = cfg_addr - CFG_AW'(BND_BASE - 1);
  assign bnd_idx = bnd_off[IDX_W-1:0];

  logic              bank_hit;
  logic [IDX_W-1:0]  bank_idx;
  spcfg_t [NSPACE-1:0] cfg_all;
  tgt_e              tgt;
  logic [ADDR_W-1:0] dec_addr;
  logic [SPW-1:0]    space;
  logic              start;
  logic              seq_rd_act, seq_wr_act;

  xmd_bank_map #(.NBANK(NBANK), .BANK_SPAN(BANK_SPAN)) bank_map_i (
    .clk(clk), .rst_n(rst_n), .bnd_we(bnd_we), .bnd_idx(bnd_idx),
    .bnd_wdata(cfg_wdata[PAGE_W-1:0]), .page(req_page),
    .hit(bank_hit), .idx(bank_idx)
  );

  xmd_space_cfg #(.NSPACE(NSPACE), .AW(CFG_AW)) space_cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_wr), .waddr(cfg_addr),
    .wdata(cfg_wdata), .cfg_o(cfg_all)
  );

  xmd_target_decode #(.NBANK(NBANK), .BOOT_PAGES(BOOT_PAGES), .IO_RSV(IO_RSV)) decode_i (
    .kind(kind_e'(req_kind)), .page(req_page), .ofs(req_offset),
    .io_pg(io_page), .io_im(io_imm), .bank_hit(bank_hit), .bank_idx(bank_idx),
    .tgt(tgt), .addr(dec_addr), .space(space)
  );

  assign start = req && !busy;

  xmd_access_seq #(.NBANK(NBANK)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt(tgt), .bank_idx(bank_idx),
    .addr(dec_addr), .cfg(cfg_all[space]), .wr(req_write), .wdata(req_wdata),
    .ext_din(ext_din), .busy(busy), .done(done), .bank_cs(bank_cs),
    .boot_cs(boot_cs), .io_cs(io_cs), .rom_sel(rom_sel), .io_onchip(io_onchip),
    .rd_strb(rd_strb), .wr_strb(wr_strb), .ext_addr(ext_addr),
    .ext_byte_hi(ext_byte_hi), .ext_dout(ext_dout), .ext_oe(ext_oe),
    .rdata(rdata), .rd_act(seq_rd_act), .wr_act(seq_wr_act)
  );
endmodule

// File: rtl/xmd_space_decoder_chk.sv
module xmd_space_decoder_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             busy,
  input logic             done,
  input logic [NBANK-1:0] bank_cs,
  input logic             boot_cs,
  input logic             io_cs,
  input logic             rom_sel,
  input logic             io_onchip,
  input logic             rd_strb,
  input logic             wr_strb,
  input logic [23:0]      ext_addr,
  input logic             rd_act,
  input logic             wr_act
);
  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bank_cs, boot_cs, io_cs}));

  // R3
  rom_no_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (bank_cs == '0) && !boot_cs && !io_cs);

  // R5
  io_rsv_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_onchip |-> !io_cs && !rom_sel);

  // R11
  strobe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act || wr_act) |-> (|{bank_cs, boot_cs, io_cs}));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_act && wr_act));

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_act && !wr_act) |-> (rd_strb == wr_strb));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && busy) |=> $stable(ext_addr));
endmodule

bind xmd_space_decoder xmd_space_decoder_chk #(.NBANK(NBANK)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
  .bank_cs(bank_cs), .boot_cs(boot_cs), .io_cs(io_cs), .rom_sel(rom_sel),
  .io_onchip(io_onchip), .rd_strb(rd_strb), .wr_strb(wr_strb),
  .ext_addr(ext_addr), .rd_act(seq_rd_act), .wr_act(seq_wr_act)
);

// File: tb/xmd_space_decoder_tb_top.sv
`timescale 1ns/1ps
module xmd_space_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [10:0] cfg_wdata = '0;
  logic        req = 1'b0;
  logic [1:0]  req_kind = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_page = '0;
  logic [15:0] req_offset = '0;
  logic [7:0]  io_page = '0;
  logic [9:0]  io_imm = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, boot_cs, io_cs, rom_sel, io_onchip;
  logic        ext_byte_hi, rd_strb, wr_strb, ext_oe;
  logic [15:0] rdata, ext_dout, ext_din;
  logic [3:0]  bank_cs;
  logic [23:0] ext_addr;

  always #2 clk = ~clk;

  // Memory model: word data is address xor A55A, high byte lane returns upper byte.
  assign ext_din = ext_byte_hi ? {8'h00, ext_addr[15:8] ^ 8'hA5} : (ext_addr[15:0] ^ 16'hA55A);

  xmd_space_decoder dut_i (.*);

  int total = 0;
  int bad   = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [10:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Results of the last access. Codes: 0 none, 1..4 bank0..3, 5 boot, 6 I/O ext, 7 ROM, 8 I/O on-chip.
  int          r_code, r_strb, r_hold;
  logic [23:0] r_addr;
  logic [15:0] r_rd;
  logic        r_first_hi, r_last_hi, r_done;
  logic [7:0]  r_first_out;

  task automatic do_acc(input logic [1:0] k, input logic [7:0] pg, input logic [15:0] of,
                        input logic [7:0] ip, input logic [9:0] im,
                        input logic w, input logic [15:0] wd, input logic pol);
    bit first = 1'b1;
    @(negedge clk);
    req_kind = k; req_page = pg; req_offset = of; io_page = ip; io_imm = im;
    req_write = w; req_wdata = wd; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    r_code = 0; r_strb = 0; r_hold = 0; r_done = 1'b0;
    r_addr = ext_addr; r_first_hi = 1'b0; r_last_hi = 1'b0; r_first_out = '0;
    for (int c = 0; c < 200; c++) begin
      if (done) begin
        if (rom_sel)   r_code = 7;
        if (io_onchip) r_code = 8;
        r_rd = rdata;
        r_done = 1'b1;
        break;
      end
      for (int b = 0; b < 4; b++) if (bank_cs[b]) r_code = b + 1;
      if (boot_cs) r_code = 5;
      if (io_cs)   r_code = 6;
      if (|{bank_cs, boot_cs, io_cs}) begin
        if ((rd_strb === pol) || (wr_strb === pol)) begin
          if (first) begin
            r_first_hi = ext_byte_hi; r_first_out = ext_dout[7:0]; first = 1'b0;
          end
          r_last_hi = ext_byte_hi;
          r_strb++;
        end else begin
          r_hold++;
        end
      end
      @(negedge clk);
    end
    chk("R11", "done seen", 32'(r_done), 32'd1);
  endtask

  // Vector table: {kind[2], page[8], offset[16], io_page[8], io_imm[10], exp_code[4]}
  localparam int NV = 16;
  localparam logic [47:0] VEC [NV] = '{
    {2'd0, 8'd1,   16'h0010, 8'd0,   10'd0,     4'd1},
    {2'd0, 8'd63,  16'hFFFF, 8'd0,   10'd0,     4'd1},
    {2'd0, 8'd64,  16'h1234, 8'd0,   10'd0,     4'd2},
    {2'd0, 8'd127, 16'h0001, 8'd0,   10'd0,     4'd2},
    {2'd0, 8'd128, 16'h8000, 8'd0,   10'd0,     4'd3},
    {2'd0, 8'd191, 16'h0F0F, 8'd0,   10'd0,     4'd3},
    {2'd0, 8'd192, 16'hABCD, 8'd0,   10'd0,     4'd4},
    {2'd0, 8'd254, 16'h5555, 8'd0,   10'd0,     4'd4},
    {2'd0, 8'd0,   16'h0100, 8'd0,   10'd0,     4'd0},
    {2'd0, 8'd255, 16'h0002, 8'd0,   10'd0,     4'd7},
    {2'd1, 8'd0,   16'h0003, 8'd0,   10'd0,     4'd5},
    {2'd1, 8'd62,  16'hC001, 8'd0,   10'd0,     4'd5},
    {2'd1, 8'd63,  16'h0004, 8'd0,   10'd0,     4'd0},
    {2'd2, 8'd0,   16'h0000, 8'd7,   10'h3FF,   4'd8},
    {2'd2, 8'd0,   16'h0000, 8'd8,   10'h000,   4'd6},
    {2'd2, 8'd0,   16'h0000, 8'd255, 10'h3FF,   4'd6}
  };

  function automatic string req_of(input int code);
    case (code)
      0:       return "R3";
      5:       return "R4";
      6, 8:    return "R5";
      7:       return "R3";
      default: return "R2";
    endcase
  endfunction

  initial begin : watchdog
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 / R11: reset state
    chk("R11", "reset busy", 32'(busy), 0);
    chk("R11", "reset done", 32'(done), 0);
    chk("R11", "reset selects", 32'({bank_cs, boot_cs, io_cs}), 0);
    chk("R8", "reset strobe levels", 32'({rd_strb, wr_strb}), 32'h3);

    // Table walk with reset configuration
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  k;  logic [7:0] pg; logic [15:0] of;
      logic [7:0]  ip; logic [9:0] im; int ec;
      logic [23:0] ea;
      {k, pg, of, ip, im} = VEC[v][47:4];
      ec = int'(VEC[v][3:0]);
      ea = (k == 2'd2) ? {6'b0, ip, im} : {pg, of};
      do_acc(k, pg, of, ip, im, 1'b0, 16'h0, 1'b0);
      chk(req_of(ec), $sformatf("vec %0d target", v), 32'(r_code), 32'(ec));
      chk("R1", $sformatf("vec %0d address", v), 32'(r_addr), 32'(ea));
      if (ec >= 1 && ec <= 6) begin
        chk("R7", $sformatf("vec %0d strobe cycles", v), 32'(r_strb), 1);
        chk("R1", $sformatf("vec %0d read data", v), 32'(r_rd), 32'(ea[15:0] ^ 16'hA55A));
      end else begin
        chk(req_of(ec), $sformatf("vec %0d no strobe", v), 32'(r_strb), 0);
      end
    end

    // R7: separate read and write wait counts on bank 1
    cfg_write(4'd1, 11'h053);
    do_acc(2'd0, 8'd70, 16'h0042, 8'd0, 10'd0, 1'b0, 16'h0, 1'b0);
    chk("R7", "read wait 3 strobe", 32'(r_strb), 4);
    do_acc(2'd0, 8'd70, 16'h0042, 8'd0, 10'd0, 1'b1, 16'h1111, 1'b0);
    chk("R7", "write wait 5 strobe", 32'(r_strb), 6);
    chk("R9", "no hold when clear", 32'(r_hold), 0);

    // R8: active-high strobe on bank 2
    cfg_write(4'd2, 11'h100);
    do_acc(2'd0, 8'd130, 16'h7777, 8'd0, 10'd0, 1'b0, 16'h0, 1'b1);
    chk("R8", "active-high target", 32'(r_code), 3);
    chk("R8", "active-high strobe cycles", 32'(r_strb), 1);
    @(negedge clk);
    chk("R8", "idle level after active-high", 32'({rd_strb, wr_strb}), 0);

    // R9: write hold extension on bank 3
    cfg_write(4'd3, 11'h210);
    do_acc(2'd0, 8'd200, 16'h0ACE, 8'd0, 10'd0, 1'b1, 16'h2222, 1'b0);
    chk("R9", "hold write strobe", 32'(r_strb), 2);
    chk("R9", "hold write extra cycle", 32'(r_hold), 1);
    do_acc(2'd0, 8'd200, 16'h0ACE, 8'd0, 10'd0, 1'b0, 16'h0, 1'b0);
    chk("R9", "read ignores hold", 32'(r_hold), 0);

    // R10: 8-bit boot space read, then write with hold
    cfg_write(4'd5, 11'h401);
    do_acc(2'd1, 8'd5, 16'h1234, 8'd0, 10'd0, 1'b0, 16'h0, 1'b0);
    chk("R10", "byte read strobe cycles", 32'(r_strb), 4);
    chk("R10", "low byte first", 32'(r_first_hi), 0);
    chk("R10", "high byte last", 32'(r_last_hi), 1);
    chk("R10", "assembled read", 32'(r_rd), 32'h1234 ^ 32'hA55A);
    cfg_write(4'd5, 11'h600);
    do_acc(2'd1, 8'd7, 16'h0001, 8'd0, 10'd0, 1'b1, 16'hBEEF, 1'b0);
    chk("R10", "byte write strobe cycles", 32'(r_strb), 2);
    chk("R10", "hold per byte", 32'(r_hold), 2);
    chk("R10", "first byte out", 32'(r_first_out), 32'hEF);

    // R6: move bank boundaries
    cfg_write(4'd8, 11'd10);
    do_acc(2'd0, 8'd9, 16'h0, 8'd0, 10'd0, 1'b0, 16'h0, 1'b0);
    chk("R6", "page 9 below moved bank1 start", 32'(r_code), 1);
    do_acc(2'd0, 8'd10, 16'h0, 8'd0, 10'd0, 1'b0, 16'h0, 1'b0);
    chk("R6", "page 10 at moved bank1 start", 32'(r_code), 2);
    cfg_write(4'd10, 11'd200);
    do_acc(2'd0, 8'd199, 16'h0, 8'd0, 10'd0, 1'b0, 16'h0, 1'b1);
    chk("R6", "page 199 below moved bank3 start", 32'(r_code), 3);
    do_acc(2'd0, 8'd200, 16'h0, 8'd0, 10'd0, 1'b0, 16'h0, 1'b0);
    chk("R6", "page 200 at moved bank3 start", 32'(r_code), 4);
    do_acc(2'd0, 8'd255, 16'h0, 8'd0, 10'd0, 1'b0, 16'h0, 1'b0);
    chk("R3", "page 255 still ROM", 32'(r_code), 7);

    // R11: request while busy is ignored
    begin
      int dones = 0;
      logic addr_ok = 1'b1;
      @(negedge clk);
      req_kind = 2'd0; req_page = 8'd70; req_offset = 16'h0042; req_write = 1'b0; req = 1'b1;
      @(negedge clk);
      req_page = 8'd230; req_offset = 16'h9999;
      @(negedge clk);
      req = 1'b0;
      for (int c = 0; c < 20; c++) begin
        if (done) dones++;
        if (|bank_cs && ext_addr !== {8'd70, 16'h0042}) addr_ok = 1'b0;
        @(negedge clk);
      end
      chk("R11", "single done under busy request", 32'(dones), 1);
      chk("R11", "address held under busy request", 32'(addr_ok), 1);
      chk("R11", "idle after access", 32'(busy), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule